// File: doc/BRIEF.md
# Buffered Asynchronous Serial Receiver

This block recovers characters from an asynchronous serial line. A sample strobe, `baud_tick`, paces an oversampling bit engine. It takes 16 samples per bit, or 8 when `dbl_speed` is high. A falling edge starts a frame, but only if the line is still low at mid-bit. Each bit is then settled by a 2-of-3 vote over the samples around the bit centre. A frame has 5 to 9 data bits sent LSB first, an optional even or odd parity bit, and one stop bit.

Finished characters go into a two-entry buffer. Each buffer entry holds the character together with its own frame, parity and overrun error marks. The outputs always show the oldest unread character and that character's own flags. One more completed character can wait behind a full buffer. That waiting character is lost if a further start bit arrives before space opens, and the next character that is stored then carries the overrun mark. In multi-processor mode the block stores only frames that carry the address marker. Clearing `rx_en` empties the buffer and drops all error state. The interrupt output is the receive-complete flag gated by a local enable and a global enable.

Top module: `uart_rx_buf`

## Requirements
- R1: After reset, `rx_complete`, `rx_irq`, `rx_data`, `rx_bit9` and the three error outputs are all zero.
- R2: Data bits arrive LSB first. The data width is set by `frame_sz`: 0→5, 1→6, 2→7, 3→8, 7→9, and any other code gives 8 bits. `rx_data` is zero above the received width. `rx_bit9` shows the ninth data bit in 9-bit mode and is 0 in all other modes.
- R3: The buffer holds two characters. `rx_complete` is high while at least one unread character is stored. A `rd_stb` pulse removes the head character. A third character completed while the buffer is full is kept, and it reaches the buffer after the next read.
- R4: `err_frame` of a character is 1 when its stop-bit sample is 0, and 0 when that sample is 1.
- R5: `par_mode` selects the parity check: 2'b10 even, 2'b11 odd, and 2'b00 or 2'b01 no parity bit. `err_parity` is 1 only when checking was on for that character and the parity bit did not match.
- R6: Overrun happens only when three things hold at once: the buffer is full, a completed character is waiting, and a new start edge is seen. The waiting character is then discarded. The next character stored gets `err_overrun` = 1. Characters stored before the overrun keep `err_overrun` = 0.
- R7: The error outputs belong to the head character. They stay unchanged until that character is read, and they are 0 when the buffer is empty.
- R8: With `dbl_speed` = 1 a bit lasts 8 samples, and with `dbl_speed` = 0 a bit lasts 16 samples.
- R9: A falling edge is not treated as a start bit if the line is high again at the mid-bit sample. No character results from it.
- R10: Each data bit is the majority of the three centre samples of the bit. A single disturbed sample among them does not change the received value.
- R11: With `mpcm` = 1, a frame is stored only if its address marker is 1. In 9-bit mode the marker is the ninth data bit. In 5 to 8 bit modes the marker is the stop bit. Frames without the marker never enter the buffer.
- R12: When `rx_en` is 0, the buffer and the waiting character are emptied on the next clock, the overrun state is cleared, and all flags read 0.
- R13: `rx_irq` is 1 exactly when `rxc_ie`, `gie` and `rx_complete` are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial line; idle level is high |
| baud_tick | input | 1 | One-cycle strobe marking one sample period |
| rx_en | input | 1 | Receiver enable; low flushes the block |
| dbl_speed | input | 1 | 8 samples per bit instead of 16 |
| mpcm | input | 1 | Store only frames that carry the address marker |
| par_mode | input | 2 | Parity selection (00/01 none, 10 even, 11 odd) |
| frame_sz | input | 3 | Data width code |
| rxc_ie | input | 1 | Local enable for the receive interrupt |
| gie | input | 1 | Global interrupt enable |
| rd_stb | input | 1 | Removes the head character |
| rx_data | output | 8 | Head character, bits 7..0 |
| rx_bit9 | output | 1 | Ninth data bit of the head character |
| err_frame | output | 1 | Frame error of the head character |
| err_parity | output | 1 | Parity error of the head character |
| err_overrun | output | 1 | Overrun mark of the head character |
| rx_complete | output | 1 | At least one unread character is stored |
| rx_irq | output | 1 | Receive-complete interrupt |

## Verification
A wrong buffer pointer or count shows up at the ports on the read that follows. Either a character comes out twice, one is skipped, or `rx_complete` stays high after the last read. Because of this, each stimulus is read back in order right away. A wrong sample counter or a wrong vote position moves the bit boundary, so the received data is shifted or has flipped bits in the same frame. At 8x that error is also seen in the first frame. Overrun and filter state can only be seen two or three frames later, at the reads. Directed sequences therefore fill the buffer, then drain it, and compare each head character together with its flags.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

    localparam int OSR_STD  = 16;
    localparam int OSR_DBL  = 8;
    localparam int MAX_DATA = 9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    // character as it leaves the bit engine
    typedef struct packed {
        logic [MAX_DATA-1:0] data;
        logic                fe;
        logic                pe;
        logic                marker;
    } rx_frame_t;

    // character as it sits in the buffer
    typedef struct packed {
        logic [MAX_DATA-1:0] data;
        logic                fe;
        logic                pe;
        logic                dor;
    } rx_entry_t;

    function automatic int data_bits(input logic [2:0] code);
        case (code)
            3'd0:    return 5;
            3'd1:    return 6;
            3'd2:    return 7;
            3'd3:    return 8;
            3'd7:    return 9;
            default: return 8;
        endcase
    endfunction

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/rxb_sampler.sv
module rxb_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rxd,
    output logic line
);
    logic [SYNC_STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain[i] <= 1'b1;
                end else if (i == 0) begin
                    chain[i] <= rxd;
                end else begin
                    chain[i] <= chain[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign line = chain[SYNC_STAGES-1];
endmodule

// File: rtl/rxb_framer.sv
module rxb_framer
    import rxb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       tick,
    input  logic       line,
    input  logic       dbl,
    input  logic [1:0] par_mode,
    input  logic [2:0] frame_sz,
    output logic       start_det,
    output logic       done,
    output rx_frame_t  frame
);
    localparam int CW = $clog2(OSR_STD);
    localparam int BW = $clog2(MAX_DATA + 1);

    rx_state_e           state;
    logic [CW-1:0]       cnt;
    logic [CW-1:0]       last_c;
    logic [CW-1:0]       mid_c;
    logic [CW-1:0]       vote_end;
    logic [1:0]          votes;
    logic [BW-1:0]       bit_idx;
    logic [BW-1:0]       nbits;
    logic [MAX_DATA-1:0] sh;
    logic [MAX_DATA-1:0] aligned;
    logic                par_acc;
    logic                pe_r;
    logic                prev_line;
    logic                bit_val;
    logic                decide;
    logic                bit_end;

    always_comb begin
        last_c   = dbl ? CW'(OSR_DBL - 1) : CW'(OSR_STD - 1);
        mid_c    = dbl ? CW'(OSR_DBL / 2) : CW'(OSR_STD / 2);
        vote_end = mid_c + CW'(1);
        nbits    = BW'(data_bits(frame_sz));
        bit_val  = vote3(votes[0], votes[1], line);
        decide   = tick && (cnt == vote_end);
        bit_end  = tick && (cnt == last_c);
        aligned  = sh >> (BW'(MAX_DATA) - nbits);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            votes     <= 2'b11;
            bit_idx   <= '0;
            sh        <= '0;
            par_acc   <= 1'b0;
            pe_r      <= 1'b0;
            prev_line <= 1'b1;
            start_det <= 1'b0;
            done      <= 1'b0;
            frame     <= '0;
        end else begin
            start_det <= 1'b0;
            done      <= 1'b0;
            if (tick) begin
                prev_line <= line;
            end
            if (state != ST_IDLE && tick) begin
                if (cnt == mid_c - CW'(1)) votes[0] <= line;
                if (cnt == mid_c)          votes[1] <= line;
                cnt <= (cnt == last_c) ? '0 : cnt + CW'(1);
            end
            case (state)
                ST_IDLE: begin
                    if (tick && prev_line && !line) begin
                        state     <= ST_START;
                        cnt       <= CW'(1);
                        start_det <= 1'b1;
                        bit_idx   <= '0;
                        par_acc   <= 1'b0;
                        pe_r      <= 1'b0;
                    end
                end
                ST_START: begin
                    if (tick && cnt == mid_c && line) begin
                        state <= ST_IDLE;
                    end else if (bit_end) begin
                        state <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (decide) begin
                        sh      <= {bit_val, sh[MAX_DATA-1:1]};
                        par_acc <= par_acc ^ bit_val;
                    end
                    if (bit_end) begin
                        if (bit_idx == nbits - BW'(1)) begin
                            state <= par_mode[1] ? ST_PAR : ST_STOP;
                        end else begin
                            bit_idx <= bit_idx + BW'(1);
                        end
                    end
                end
                ST_PAR: begin
                    if (decide) begin
                        pe_r <= par_acc ^ bit_val ^ par_mode[0];
                    end
                    if (bit_end) begin
                        state <= ST_STOP;
                    end
                end
                ST_STOP: begin
                    if (decide) begin
                        done         <= 1'b1;
                        frame.data   <= aligned;
                        frame.fe     <= !bit_val;
                        frame.pe     <= pe_r;
                        frame.marker <= (nbits == BW'(MAX_DATA)) ? aligned[MAX_DATA-1] : bit_val;
                        state        <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rxb_fifo.sv
module rxb_fifo
    import rxb_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic                       push,
    input  rx_entry_t                  din,
    input  logic                       pop,
    output rx_entry_t                  head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       empty,
    output logic                       full
);
    localparam int PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNW = $clog2(DEPTH + 1);

    rx_entry_t         mem [DEPTH];
    logic [PW-1:0]     wp;
    logic [PW-1:0]     rp;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) begin
                mem[wp] <= din;
                wp      <= nxt(wp);
            end
            if (pop) begin
                rp <= nxt(rp);
            end
            case ({push, pop})
                2'b10:   count <= count + CNW'(1);
                2'b01:   count <= count - CNW'(1);
                default: count <= count;
            endcase
        end
    end

    assign head  = mem[rp];
    assign empty = (count == '0);
    assign full  = (count == CNW'(DEPTH));
endmodule

// File: rtl/uart_rx_buf.sv
module uart_rx_buf
    import rxb_pkg::*;
#(
    parameter int BUF_DEPTH   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rxd,
    input  logic       baud_tick,
    input  logic       rx_en,
    input  logic       dbl_speed,
    input  logic       mpcm,
    input  logic [1:0] par_mode,
    input  logic [2:0] frame_sz,
    input  logic       rxc_ie,
    input  logic       gie,
    input  logic       rd_stb,
    output logic [7:0] rx_data,
    output logic       rx_bit9,
    output logic       err_frame,
    output logic       err_parity,
    output logic       err_overrun,
    output logic       rx_complete,
    output logic       rx_irq
);
    localparam int CNW = $clog2(BUF_DEPTH + 1);

    logic           line;
    logic           start_det;
    logic           frm_done;
    rx_frame_t      frm;
    rx_entry_t      head;
    rx_entry_t      pend;
    rx_entry_t      new_entry;
    rx_entry_t      push_data;
    logic           pend_v;
    logic           ovr_mark;
    logic [CNW-1:0] buf_cnt;
    logic           empty;
    logic           full;
    logic           accept;
    logic           pop;
    logic           space;
    logic           push_pend;
    logic           push_new;
    logic           hold_new;
    logic           ovr_hit;

    rxb_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_samp (
        .clk  (clk),
        .rst  (rst),
        .rxd  (rxd),
        .line (line)
    );

    rxb_framer u_frm (
        .clk       (clk),
        .rst       (rst),
        .run       (rx_en),
        .tick      (baud_tick),
        .line      (line),
        .dbl       (dbl_speed),
        .par_mode  (par_mode),
        .frame_sz  (frame_sz),
        .start_det (start_det),
        .done      (frm_done),
        .frame     (frm)
    );

    always_comb begin
        accept    = frm_done && (!mpcm || frm.marker);
        pop       = rd_stb && !empty && rx_en;
        space     = !full || pop;
        push_pend = pend_v && space;
        push_new  = accept && space && !pend_v;
        hold_new  = accept && !push_new;
        ovr_hit   = start_det && pend_v && full && !pop;
        new_entry = '{data: frm.data, fe: frm.fe, pe: frm.pe, dor: ovr_mark};
        push_data = push_pend ? pend : new_entry;
    end

    rxb_fifo #(.DEPTH(BUF_DEPTH)) u_buf (
        .clk   (clk),
        .rst   (rst),
        .flush (!rx_en),
        .push  (push_pend || push_new),
        .din   (push_data),
        .pop   (pop),
        .head  (head),
        .count (buf_cnt),
        .empty (empty),
        .full  (full)
    );

    // character waiting behind a full buffer, plus the overrun mark
    always_ff @(posedge clk) begin
        if (rst || !rx_en) begin
            pend     <= '0;
            pend_v   <= 1'b0;
            ovr_mark <= 1'b0;
        end else begin
            if (hold_new) begin
                pend     <= new_entry;
                pend_v   <= 1'b1;
                ovr_mark <= 1'b0;
            end else if (push_pend) begin
                pend_v <= 1'b0;
            end else if (ovr_hit) begin
                pend_v   <= 1'b0;
                ovr_mark <= 1'b1;
            end
            if (push_new) begin
                ovr_mark <= 1'b0;
            end
        end
    end

    assign rx_complete = !empty;
    assign rx_data     = head.data[7:0] & {8{!empty}};
    assign rx_bit9     = head.data[8] & !empty;
    assign err_frame   = head.fe & !empty;
    assign err_parity  = head.pe & !empty;
    assign err_overrun = head.dor & !empty;
    assign rx_irq      = rxc_ie & gie & !empty;
endmodule

// File: rtl/rxb_chk.sv
module rxb_chk #(
    parameter int DEPTH = 2
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       rx_en,
    input logic                       rd_stb,
    input logic                       rxc_ie,
    input logic                       gie,
    input logic [7:0]                 rx_data,
    input logic                       rx_bit9,
    input logic                       err_frame,
    input logic                       err_parity,
    input logic                       err_overrun,
    input logic                       rx_complete,
    input logic                       rx_irq,
    input logic [$clog2(DEPTH+1)-1:0] occ
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        occ <= ($clog2(DEPTH+1))'(DEPTH)); // R3

    AST_HEAD_KEPT: assert property (@(posedge clk) disable iff (rst)
        (rx_complete && !rd_stb && rx_en) |=> rx_complete); // R3

    AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (rst)
        (rx_complete && !rd_stb && rx_en) |=>
            ($stable(rx_data) && $stable(rx_bit9) && $stable(err_frame)
             && $stable(err_parity) && $stable(err_overrun))); // R7

    AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (rst)
        !rx_complete |-> !(err_frame || err_parity || err_overrun || rx_bit9)); // R7

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> !rx_complete); // R12

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        rx_irq |-> (rx_complete && rxc_ie && gie)); // R13
endmodule

bind uart_rx_buf rxb_chk #(.DEPTH(BUF_DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rx_en       (rx_en),
    .rd_stb      (rd_stb),
    .rxc_ie      (rxc_ie),
    .gie         (gie),
    .rx_data     (rx_data),
    .rx_bit9     (rx_bit9),
    .err_frame   (err_frame),
    .err_parity  (err_parity),
    .err_overrun (err_overrun),
    .rx_complete (rx_complete),
    .rx_irq      (rx_irq),
    .occ         (buf_cnt)
);

// File: tb/uart_rx_buf_test.sv
module uart_rx_buf_test;
    localparam int CLK_PERIOD = 10;
    localparam int TICKDIV    = 2;

    logic       clk = 1'b0;
    logic       rst;
    logic       rxd;
    logic       baud_tick;
    logic       rx_en;
    logic       dbl_speed;
    logic       mpcm;
    logic [1:0] par_mode;
    logic [2:0] frame_sz;
    logic       rxc_ie;
    logic       gie;
    logic       rd_stb;
    logic [7:0] rx_data;
    logic       rx_bit9;
    logic       err_frame;
    logic       err_parity;
    logic       err_overrun;
    logic       rx_complete;
    logic       rx_irq;

    int n_checks = 0;
    int n_fail   = 0;

    uart_rx_buf uut (
        .clk(clk), .rst(rst), .rxd(rxd), .baud_tick(baud_tick), .rx_en(rx_en),
        .dbl_speed(dbl_speed), .mpcm(mpcm), .par_mode(par_mode), .frame_sz(frame_sz),
        .rxc_ie(rxc_ie), .gie(gie), .rd_stb(rd_stb), .rx_data(rx_data),
        .rx_bit9(rx_bit9), .err_frame(err_frame), .err_parity(err_parity),
        .err_overrun(err_overrun), .rx_complete(rx_complete), .rx_irq(rx_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        baud_tick = 1'b0;
        for (int t = 0; ; t++) begin
            @(negedge clk);
            baud_tick = ((t % TICKDIV) == 0);
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    function automatic int nbits_of(input logic [2:0] code);
        case (code)
            3'd0: return 5;
            3'd1: return 6;
            3'd2: return 7;
            3'd3: return 8;
            3'd7: return 9;
            default: return 8;
        endcase
    endfunction

    function automatic logic [8:0] msk(input logic [8:0] d, input int n);
        return d & ((9'h1 << n) - 9'h1);
    endfunction

    // drive one frame using the current speed, size and parity settings
    task automatic send(input logic [8:0] d, input bit bad_par, input bit stop_val,
                        input bit glitch);
        int n     = nbits_of(frame_sz);
        int osr   = dbl_speed ? 8 : 16;
        int total = 0;
        logic [12:0] fr = '1;
        logic [8:0]  dm = msk(d, n);
        fr[total++] = 1'b0;
        for (int i = 0; i < n; i++) fr[total++] = dm[i];
        if (par_mode[1]) fr[total++] = (^dm) ^ par_mode[0] ^ bad_par;
        fr[total++] = stop_val;
        for (int b = 0; b < total; b++) begin
            for (int j = 0; j < osr; j++) begin
                rxd = fr[b] ^ (glitch && b == 1 && j == osr/2 + 1);
                repeat (TICKDIV) @(negedge clk);
            end
        end
        rxd = 1'b1;
        repeat (osr * TICKDIV * 2) @(negedge clk);
    endtask

    task automatic read_head(input logic [8:0] d, input int n, input bit fe, input bit pe,
                             input bit dor, input string req);
        logic [8:0] dm = msk(d, n);
        check(rx_complete == 1'b1, {req, " present"}, rx_complete, 1);
        check(rx_data == dm[7:0], {req, " data"}, rx_data, dm[7:0]);
        check(rx_bit9 == ((n == 9) ? dm[8] : 1'b0), "R2 bit9", rx_bit9, (n == 9) ? dm[8] : 1'b0);
        check(err_frame == fe, {req, " R4 frame flag"}, err_frame, fe);
        check(err_parity == pe, {req, " R5 parity flag"}, err_parity, pe);
        check(err_overrun == dor, {req, " R6 overrun flag"}, err_overrun, dor);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [8:0] v [4];
        void'($urandom(32'd4117));
        rst = 1'b1; rxd = 1'b1; rx_en = 1'b1; dbl_speed = 1'b0; mpcm = 1'b0;
        par_mode = 2'b00; frame_sz = 3'd3; rxc_ie = 1'b0; gie = 1'b0; rd_stb = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check({rx_complete, rx_irq, rx_data, rx_bit9, err_frame, err_parity, err_overrun} == '0,
              "R1 reset outputs",
              {rx_complete, rx_irq, rx_data, rx_bit9, err_frame, err_parity, err_overrun}, 0);

        // R2 R8 R10: glitch on a centre sample at both speeds
        send(9'h0A5, 1'b0, 1'b1, 1'b1);
        read_head(9'h0A5, 8, 0, 0, 0, "R10 vote 16x");
        dbl_speed = 1'b1;
        send(9'h03C, 1'b0, 1'b1, 1'b1);
        read_head(9'h03C, 8, 0, 0, 0, "R8 R10 vote 8x");
        dbl_speed = 1'b0;

        // R9 short low pulse is not a start bit
        rxd = 1'b0;
        repeat (3 * TICKDIV) @(negedge clk);
        rxd = 1'b1;
        repeat (40 * TICKDIV) @(negedge clk);
        check(rx_complete == 1'b0, "R9 rejected start", rx_complete, 0);
        send(9'h05A, 1'b0, 1'b1, 1'b0);
        read_head(9'h05A, 8, 0, 0, 0, "R9 frame after reject");

        // R3 R6: three frames held, then overrun on a fourth start
        for (int i = 0; i < 4; i++) v[i] = 9'(i * 37 + 11);
        for (int i = 0; i < 3; i++) send(v[i], 1'b0, 1'b1, 1'b0);
        check(rx_complete == 1'b1, "R3 full buffer present", rx_complete, 1);
        read_head(v[0], 8, 0, 0, 0, "R3 first");
        read_head(v[1], 8, 0, 0, 0, "R3 second");
        read_head(v[2], 8, 0, 0, 0, "R3 waiting char delivered");
        check(rx_complete == 1'b0, "R3 drained", rx_complete, 0);
        for (int i = 0; i < 4; i++) send(v[i], 1'b0, 1'b1, 1'b0);
        read_head(v[0], 8, 0, 0, 0, "R6 older char clean");
        read_head(v[1], 8, 0, 0, 0, "R6 older char clean");
        read_head(v[3], 8, 0, 0, 1, "R6 char after overrun");
        check(rx_complete == 1'b0, "R6 waiting char dropped", rx_complete, 0);

        // R7 R12: frame error on head, then disable flushes
        send(9'h0F0, 1'b0, 1'b0, 1'b0);
        send(9'h00F, 1'b0, 1'b1, 1'b0);
        check(err_frame == 1'b1, "R7 head flag is head's own", err_frame, 1);
        rx_en = 1'b0;
        repeat (2) @(negedge clk);
        check({rx_complete, err_frame, err_parity, err_overrun} == '0, "R12 flush",
              {rx_complete, err_frame, err_parity, err_overrun}, 0);
        rx_en = 1'b1;
        repeat (4) @(negedge clk);

        // R11 multi-processor filtering, 9-bit and 8-bit
        mpcm = 1'b1; frame_sz = 3'd7;
        send(9'h055, 1'b0, 1'b1, 1'b0);
        check(rx_complete == 1'b0, "R11 9-bit data frame dropped", rx_complete, 0);
        send(9'h155, 1'b0, 1'b1, 1'b0);
        read_head(9'h155, 9, 0, 0, 0, "R11 9-bit address kept");
        frame_sz = 3'd3;
        send(9'h066, 1'b0, 1'b0, 1'b0);
        check(rx_complete == 1'b0, "R11 8-bit marker zero dropped", rx_complete, 0);
        send(9'h067, 1'b0, 1'b1, 1'b0);
        read_head(9'h067, 8, 0, 0, 0, "R11 8-bit address kept");
        mpcm = 1'b0;

        // R13 interrupt gating
        send(9'h011, 1'b0, 1'b1, 1'b0);
        for (int k = 0; k < 4; k++) begin
            rxc_ie = k[0]; gie = k[1];
            @(negedge clk);
            check(rx_irq == (k == 3), "R13 irq gating", rx_irq, k == 3);
        end
        read_head(9'h011, 8, 0, 0, 0, "R13 char");
        check(rx_irq == 1'b0, "R13 irq after drain", rx_irq, 0);

        // R2 R4 R5 R8 random frames
        for (int it = 0; it < 40; it++) begin
            logic [2:0] codes [5] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd7};
            logic [8:0] d   = 9'($urandom);
            bit         bp  = ($urandom % 4) == 0;
            bit         sv  = ($urandom % 6) != 0;
            int         n;
            frame_sz  = (($urandom % 8) == 0) ? 3'd5 : codes[$urandom % 5];
            par_mode  = 2'($urandom);
            dbl_speed = $urandom % 2;
            n = nbits_of(frame_sz);
            send(d, bp, sv, 1'b0);
            read_head(d, n, !sv, par_mode[1] && bp, 0, "R2 R5 R8 random");
            check(rx_complete == 1'b0, "R3 empty after read", rx_complete, 0);
        end

        summary();
        $finish;
    end
endmodule